// File: doc/BRIEF.md
# Parallel Response Signature Compactor

This block folds a stream of N-bit parallel test responses into a single N-bit signature. It is meant for built-in self-test: each clock in which capture is enabled, the current signature and the response word are combined into the next signature by a shift-register structure with linear feedback. At the end of a test the accumulated signature is compared with a known-good (golden) value, and a registered pass/done pair reports the outcome.

Every stage of the register mixes in its own bit of the response word. The lowest stage also takes the parity of the stages selected by a tap mask. A parameter switches the combining gates from XOR to XNOR, so that the all-zero state is no longer a fixed point. Compaction is lossy: a faulty response stream can produce the golden signature. Such aliasing is accepted and reported as a pass.

Top module: `misr_compactor`

## Requirements
- R1: After reset the signature equals the parameter RESET_SEED (default 0), and both testDone and testPass are 0.
- R2: When seedLoad is high at a clock edge, the signature takes seedValue, and testDone and testPass clear to 0. This overrides captureEn and compareStrobe in the same cycle.
- R3: When captureEn is high and seedLoad is low, the next value of signature bit 0 is dataIn bit 0 XOR the parity of (signature AND TAP_MASK). TAP_MASK bit k selects signature bit k. The default mask is 4'b1100.
- R4: When capturing, the next value of signature bit i (i > 0) is signature bit i-1 XOR dataIn bit i.
- R5: When captureEn and seedLoad are both low, the signature holds its value.
- R6: compareStrobe, while testDone is 0 and seedLoad is low, sets testDone to 1 on the next edge. testPass becomes 1 exactly when the signature equals goldenSig in the strobe cycle.
- R7: Once testDone is 1, testDone and testPass hold until a seedLoad. Further compare strobes are ignored.
- R8: With USE_XNOR=1 every stage result in R3 and R4 is complemented. From the all-zero state with zero data, the next signature is all ones. With XOR and zero data, the all-zero state stays at zero.
- R9: The same seed and input sequence always give the same signature. With the default maximal mask, flipping a single input bit in one cycle changes the final signature.
- R10: A faulty stream that aliases is reported as a pass. An example is an error in bit 0 at cycle t followed by an error in bit 1 at cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load seedValue and clear the result |
| seedValue | input | N | Starting signature |
| captureEn | input | 1 | Fold dataIn into the signature this cycle |
| dataIn | input | N | Parallel test response word |
| compareStrobe | input | 1 | Compare the signature with goldenSig |
| goldenSig | input | N | Expected final signature |
| signature | output | N | Current signature |
| testDone | output | 1 | A compare has been taken since the last load |
| testPass | output | 1 | The compared signature matched |

## Verification
A wrong stage equation or tap selection shows on the signature port one cycle after the first capture that exercises it. The bench compares the signature against a reference model after every cycle, so the divergence is caught in that same cycle. A wrong comparison or a result that fails to hold shows on testPass and testDone one edge after the strobe, or at a later ignored strobe. The single-bit flip and the cancelling-error cases check that errors propagate through the stages as the linear equations predict.

// File: rtl/misr_pkg.sv
package misr_pkg;
  typedef struct packed {
    logic load;
    logic capture;
    logic compare;
  } misrStrobe_t;
endpackage

// File: rtl/misr_ctrl.sv
module misr_ctrl
  import misr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedLoad,
  input  logic        captureEn,
  input  logic        compareStrobe,
  input  logic        matchNow,
  output misrStrobe_t strobe,
  output logic        testDone,
  output logic        testPass
);
  always_comb begin
    strobe.load    = seedLoad;
    strobe.capture = captureEn & ~seedLoad;
    strobe.compare = compareStrobe & ~seedLoad & ~testDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testDone <= 1'b0;
      testPass <= 1'b0;
    end else if (strobe.load) begin
      testDone <= 1'b0;
      testPass <= 1'b0;
    end else if (strobe.compare) begin
      testDone <= 1'b1;
      testPass <= matchNow;
    end
  end

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testDone && !seedLoad) |=> (testDone && $stable(testPass)));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (compareStrobe && !seedLoad) |=> testDone);

  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> (!testDone && !testPass));
endmodule

// File: rtl/misr_datapath.sv
module misr_datapath
  import misr_pkg::*;
#(
  parameter int              N          = 4,
  parameter logic [N-1:0]    TAP_MASK   = 4'b1100,
  parameter logic [N-1:0]    RESET_SEED = '0,
  parameter bit              USE_XNOR   = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  misrStrobe_t  strobe,
  input  logic [N-1:0] seedValue,
  input  logic [N-1:0] dataIn,
  input  logic [N-1:0] goldenSig,
  output logic [N-1:0] signature,
  output logic         matchNow
);
  localparam logic INV = USE_XNOR;

  logic [N-1:0] sigQ;
  logic [N-1:0] sigNext;
  logic         feedback;

  assign feedback = ^(sigQ & TAP_MASK);

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign sigNext[i] = dataIn[i] ^ feedback ^ INV;
      end else begin : g_body
        assign sigNext[i] = sigQ[i-1] ^ dataIn[i] ^ INV;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)               sigQ <= RESET_SEED;
    else if (strobe.load)    sigQ <= seedValue;
    else if (strobe.capture) sigQ <= sigNext;
  end

  assign signature = sigQ;
  assign matchNow  = (sigQ == goldenSig);

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.capture) |=> $stable(sigQ));

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (sigQ == $past(seedValue)));

  // R4
  shift_body_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (sigQ[N-1:1] ==
      ($past(sigQ[N-2:0]) ^ $past(dataIn[N-1:1]) ^ {(N-1){INV}})));
endmodule

// File: rtl/misr_compactor.sv
module misr_compactor
  import misr_pkg::*;
#(
  parameter int           N          = 4,
  parameter logic [N-1:0] TAP_MASK   = 4'b1100,
  parameter logic [N-1:0] RESET_SEED = '0,
  parameter bit           USE_XNOR   = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         seedLoad,
  input  logic [N-1:0] seedValue,
  input  logic         captureEn,
  input  logic [N-1:0] dataIn,
  input  logic         compareStrobe,
  input  logic [N-1:0] goldenSig,
  output logic [N-1:0] signature,
  output logic         testDone,
  output logic         testPass
);
  misrStrobe_t strobe;
  logic        matchNow;

  misr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .captureEn(captureEn),
    .compareStrobe(compareStrobe), .matchNow(matchNow), .strobe(strobe),
    .testDone(testDone), .testPass(testPass)
  );

  misr_datapath #(
    .N(N), .TAP_MASK(TAP_MASK), .RESET_SEED(RESET_SEED), .USE_XNOR(USE_XNOR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seedValue(seedValue),
    .dataIn(dataIn), .goldenSig(goldenSig), .signature(signature),
    .matchNow(matchNow)
  );
endmodule

// File: tb/sim_misr_compactor.sv
module sim_misr_compactor;
  localparam logic [3:0] TAP = 4'b1100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seedLoad = 0, captureEn = 0, compareStrobe = 0;
  logic [3:0] seedValue = 0, dataIn = 0, goldenSig = 0;
  logic [3:0] signature;
  logic testDone, testPass;

  logic xLoad = 0, xCap = 0;
  logic [3:0] xSeed = 0, xData = 0;
  logic [3:0] xSig;
  logic xDone, xPass;

  int checks = 0;
  int fails = 0;
  logic [3:0] words [16];

  always #2 clk = ~clk;

  misr_compactor u0 (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedValue(seedValue),
    .captureEn(captureEn), .dataIn(dataIn), .compareStrobe(compareStrobe),
    .goldenSig(goldenSig), .signature(signature), .testDone(testDone),
    .testPass(testPass)
  );

  misr_compactor #(.USE_XNOR(1'b1)) uX (
    .clk(clk), .rstN(rstN), .seedLoad(xLoad), .seedValue(xSeed),
    .captureEn(xCap), .dataIn(xData), .compareStrobe(1'b0),
    .goldenSig(4'h0), .signature(xSig), .testDone(xDone), .testPass(xPass)
  );

  function automatic logic [3:0] modelNext(input logic [3:0] s, input logic [3:0] d,
                                           input bit inv);
    logic [3:0] n;
    n = {s[2:0] ^ d[3:1], d[0] ^ (^(s & TAP))};
    return inv ? ~n : n;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    seedLoad = 0; captureEn = 0; compareStrobe = 0; xLoad = 0; xCap = 0;
  endtask

  task automatic runSeq(input logic [3:0] seed, input int errCycA, input logic [3:0] errA,
                        input int errCycB, input logic [3:0] errB, output logic [3:0] hw,
                        output logic [3:0] mdl);
    logic [3:0] m;
    seedLoad = 1; seedValue = seed; tick();
    m = seed;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] d;
      d = words[c];
      if (c == errCycA) d = d ^ errA;
      if (c == errCycB) d = d ^ errB;
      captureEn = 1; dataIn = d; tick();
      m = modelNext(m, d, 1'b0);
    end
    hw = signature; mdl = m;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] exp, hwA, mA, hwB, mB, xe;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1 signature", signature, 4'h0);
    check("R1 done/pass", {2'b0, testDone, testPass}, 4'h0);

    // R2 load overrides capture and compare
    seedLoad = 1; seedValue = 4'hA; captureEn = 1; dataIn = 4'h5;
    compareStrobe = 1; goldenSig = 4'h0; tick();
    check("R2 seed load", signature, 4'hA);
    check("R2 done clear", {3'b0, testDone}, 4'h0);

    // R3 R4 R5 random capture
    exp = 4'hA;
    for (int k = 0; k < 60; k++) begin
      logic [3:0] d;
      logic en;
      d = 4'($urandom); en = 1'($urandom);
      captureEn = en; dataIn = d; tick();
      if (en) begin
        exp = modelNext(exp, d, 1'b0);
        check("R3 stage0", {3'b0, signature[0]}, {3'b0, exp[0]});
        check("R4 upper stages", signature, exp);
      end else begin
        check("R5 hold", signature, exp);
      end
    end

    // R6 matching compare
    goldenSig = exp; compareStrobe = 1; tick();
    check("R6 done/pass match", {2'b0, testDone, testPass}, 4'b0011);
    // R7 later compare ignored
    goldenSig = ~exp; compareStrobe = 1; tick();
    check("R7 result held", {2'b0, testDone, testPass}, 4'b0011);
    // R2 clear, then R6 mismatch
    seedLoad = 1; seedValue = 4'h3; tick();
    check("R2 result cleared", {2'b0, testDone, testPass}, 4'b0000);
    goldenSig = 4'hC; compareStrobe = 1; tick();
    check("R6 mismatch", {2'b0, testDone, testPass}, 4'b0010);

    // R9 determinism and single-bit flip
    for (int c = 0; c < 16; c++) words[c] = 4'($urandom);
    runSeq(4'h7, -1, 4'h0, -1, 4'h0, hwA, mA);
    check("R9 clean model", hwA, mA);
    runSeq(4'h7, -1, 4'h0, -1, 4'h0, hwB, mB);
    check("R9 repeatable", hwB, hwA);
    runSeq(4'h7, 5, 4'h4, -1, 4'h0, hwB, mB);
    check("R9 flip model", hwB, mB);
    checks++;
    if (hwB === hwA) begin
      fails++;
      $display("FAIL R9 flip undetected actual=%h expected!=%h", hwB, hwA);
    end

    // R10 aliasing pair passes
    runSeq(4'h7, 5, 4'h1, 6, 4'h2, hwB, mB);
    check("R10 alias signature", hwB, mA);
    goldenSig = mA; compareStrobe = 1; tick();
    check("R10 alias pass", {2'b0, testDone, testPass}, 4'b0011);

    // R8 XOR zero lock vs XNOR escape
    seedLoad = 1; seedValue = 4'h0; xLoad = 1; xSeed = 4'h0; tick();
    captureEn = 1; dataIn = 4'h0; xCap = 1; xData = 4'h0; tick();
    check("R8 xor zero stays", signature, 4'h0);
    check("R8 xnor leaves zero", xSig, 4'hF);
    xe = 4'hF;
    for (int k = 0; k < 20; k++) begin
      logic [3:0] d;
      d = 4'($urandom);
      xCap = 1; xData = d; tick();
      xe = modelNext(xe, d, 1'b1);
      check("R8 xnor model", xSig, xe);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule